// File: doc/BRIEF.md
# Option-Bus I/O Master with Conflict Retry and Timeout

This block sits between a processor's uncached I/O path and a shared option bus built from fixed-size slot windows. It accepts one single-word read or write at a time from the processor side, drives the word onto the bus with a one-hot select for the addressed slot, and waits for the option to finish it. An option may finish normally with an acknowledge, or push back with a conflict, in which case the master drops the select and issues the same transaction again, as often as needed. If the option stays silent for too long, the master gives up and returns a bus-error flag.

Pacing rules are built in. A read is never answered sooner than a fixed minimum number of cycles after it was taken. Write selects are never started closer together than a fixed spacing, including reissues. Both the request and the response use valid/ready. A request is taken on any cycle where `req_valid` and `req_ready` are both high. `req_ready` is high when the master is idle, and also in the cycle its pending response is being taken. A response stays on `rsp_valid` with fixed data until `rsp_ready` takes it, and no new request is taken while a response waits.

Top module: `iob_master`

## Requirements
- R1: While a transaction is on the bus exactly one `bus_sel` bit is high. It is the bit whose index equals request address bits [WIN_BITS+SLOT_BITS-1:WIN_BITS] (bits [24:22] by default). `bus_addr`, `bus_write` (1 = write), `bus_wdata` and `bus_mask` carry the request's fields. When the spacing rule of R8 does not hold it back, the select rises in the cycle after the request is taken.
- R2: `req_ready` is high when idle and low while any select is high. A response that is not taken holds `rsp_valid`, `rsp_rdata` and `rsp_err` unchanged.
- R3: An acknowledge without conflict in a selected cycle ends the transaction, and all selects are low in the next cycle. A read returns the `bus_rdata` value sampled in the acknowledge cycle, with `rsp_err` = 0.
- R4: A conflict in a selected cycle wins over an acknowledge in the same cycle. All selects are low in the next cycle, and the same slot, address, data and direction are selected again later. Conflicts are retried without limit.
- R5: After TIMEOUT (255) consecutive selected cycles with neither acknowledge nor conflict, the select drops in the next cycle. The response then carries `rsp_err` = 1 and `rsp_rdata` = 0.
- R6: Each reissue after a conflict gets a fresh TIMEOUT window of selected cycles, however long the conflicted attempt ran.
- R7: A read's response is never valid earlier than READ_MIN (8) cycles after the cycle it was taken. With the acknowledge in the first selected cycle, it is valid exactly then.
- R8: The first selected cycles of any two write attempts, reissues included, are at least WRITE_GAP (3) cycles apart. Back-to-back writes acknowledged at once start exactly 3 cycles apart.
- R9: A write's response is valid in the cycle after its acknowledge, with `rsp_err` = 0 and `rsp_rdata` = 0.
- R10: During and right after reset (`rst_n` low, active-low), `bus_sel` is 0, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address including slot field |
| req_wdata | input | DATA_W | Write word |
| req_mask | input | DATA_W/8 | Byte lane enables for writes |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_rdata | output | DATA_W | Read word (0 for writes and errors) |
| rsp_err | output | 1 | Transaction timed out |
| bus_sel | output | 2**SLOT_BITS | One-hot slot select |
| bus_addr | output | ADDR_W | Address of current transaction |
| bus_write | output | 1 | Direction, 1 = write |
| bus_wdata | output | DATA_W | Write word on the bus |
| bus_mask | output | DATA_W/8 | Byte lane enables on the bus |
| bus_rdata | input | DATA_W | Read word from the option |
| bus_ack | input | 1 | Option completes the transaction |
| bus_conflict | input | 1 | Option asks for a reissue |

## Verification
A corrupted state register or timer shows up at the bus pins within one cycle of the event that should have moved it. A select can stay high after an acknowledge or conflict, stay low after a backoff, or end its window at the wrong length. The reissue gap, the timeout window and the 3-cycle write spacing are measured at the select pins, cycle by cycle. A wrong latency counter or capture register shows up at the response side, as a read answered earlier than 8 cycles after it was taken or as data that does not match the acknowledge cycle. The bench times each response against the cycle its request was taken, so an off-by-one in any counter shows as a latency mismatch.

// File: rtl/iob_pkg.sv
package iob_pkg;
  // Transaction phases of the master.
  typedef enum logic [2:0] {
    ST_IDLE,  // no transaction held
    ST_WAIT,  // taken, held back by write spacing
    ST_SEL,   // select driven on the bus
    ST_BACK,  // select released after a conflict
    ST_DONE   // response waiting for the processor side
  } iob_state_e;
endpackage

// File: rtl/iob_slot_dec.sv
module iob_slot_dec #(
  parameter int SLOT_BITS = 3,
  localparam int SLOTS = 1 << SLOT_BITS
) (
  input  logic [SLOT_BITS-1:0] idx,
  input  logic                 en,
  output logic [SLOTS-1:0]     sel
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign sel[s] = en && (idx == SLOT_BITS'(s));
  end
endmodule

// File: rtl/iob_tmo_timer.sv
module iob_tmo_timer #(
  parameter int TIMEOUT = 255,
  localparam int TMO_W = $clog2(TIMEOUT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,  // select is driven this cycle
  input  logic term,    // ack or conflict seen this cycle
  output logic expire   // last allowed selected cycle passes silently
);
  logic [TMO_W-1:0] cnt_q;

  // Counter clears whenever the select is not driven, so every reissue
  // starts a fresh window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!active || term) cnt_q <= '0;
    else if (!expire)         cnt_q <= cnt_q + 1'b1;
    else                      cnt_q <= '0;
  end

  assign expire = active && !term && (cnt_q == TMO_W'(TIMEOUT - 1));
endmodule

// File: rtl/iob_pace.sv
module iob_pace #(
  parameter int READ_MIN  = 8,
  parameter int WRITE_GAP = 3,
  localparam int LAT_W = $clog2(READ_MIN + 1),
  localparam int GAP_W = $clog2(WRITE_GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,        // request taken this cycle
  input  logic wr_sel_start,  // first selected cycle of a write attempt
  output logic lat_ok,        // minimum read latency reached
  output logic gap_free       // a write select may start next cycle
);
  logic [LAT_W-1:0] lat_q;
  logic [GAP_W-1:0] gap_q, gap_nxt;

  // Age of the held request: cycle of acceptance + k shows k.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lat_q <= LAT_W'(READ_MIN);
    else if (accept)                     lat_q <= LAT_W'(1);
    else if (lat_q != LAT_W'(READ_MIN))  lat_q <= lat_q + 1'b1;
  end
  assign lat_ok = (lat_q >= LAT_W'(READ_MIN));

  // Cycles still barred for a write select start.
  always_comb begin
    if (wr_sel_start)       gap_nxt = GAP_W'(WRITE_GAP - 1);
    else if (gap_q != '0)   gap_nxt = gap_q - 1'b1;
    else                    gap_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else        gap_q <= gap_nxt;
  end
  assign gap_free = (gap_nxt == '0);
endmodule

// File: rtl/iob_master.sv
module iob_master import iob_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int WIN_BITS  = 22,
  parameter int SLOT_BITS = 3,
  parameter int TIMEOUT   = 255,
  parameter int READ_MIN  = 8,
  parameter int WRITE_GAP = 3,
  localparam int SLOTS  = 1 << SLOT_BITS,
  localparam int MASK_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [MASK_W-1:0] req_mask,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [SLOTS-1:0]  bus_sel,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [MASK_W-1:0] bus_mask,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_conflict
);
  iob_state_e st_q, st_d;

  logic              wr_q, first_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [MASK_W-1:0] mask_q;

  logic in_sel, ack_hit, conf_hit, expire;
  logic accept, rsp_fire, lat_ok, gap_free, wr_sel_start;
  iob_state_e launch;

  assign in_sel   = (st_q == ST_SEL);
  assign conf_hit = in_sel && bus_conflict;          // conflict wins
  assign ack_hit  = in_sel && bus_ack && !bus_conflict;
  assign wr_sel_start = in_sel && first_q && wr_q;

  assign rsp_valid = (st_q == ST_DONE) && (wr_q || lat_ok);
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign req_ready = (st_q == ST_IDLE) || rsp_fire;
  assign accept    = req_valid && req_ready;

  // A newly taken write may have to wait out the spacing window.
  assign launch = (req_write && !gap_free) ? ST_WAIT : ST_SEL;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = launch;
      ST_WAIT,
      ST_BACK: if (!wr_q || gap_free) st_d = ST_SEL;
      ST_SEL: begin
        if (conf_hit)               st_d = ST_BACK;
        else if (ack_hit || expire) st_d = ST_DONE;
      end
      ST_DONE: if (rsp_fire) st_d = accept ? launch : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      first_q <= (st_d == ST_SEL) && (st_q != ST_SEL);
    end
  end

  // Request capture.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  // Result capture: read word taken in the acknowledge cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else if (ack_hit) begin
      rdata_q <= wr_q ? '0 : bus_rdata;
      err_q   <= 1'b0;
    end else if (expire) begin
      rdata_q <= '0;
      err_q   <= 1'b1;
    end
  end

  iob_slot_dec #(.SLOT_BITS(SLOT_BITS)) u_dec (
    .idx (addr_q[WIN_BITS +: SLOT_BITS]),
    .en  (in_sel),
    .sel (bus_sel)
  );

  iob_tmo_timer #(.TIMEOUT(TIMEOUT)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (in_sel),
    .term   (bus_ack || bus_conflict),
    .expire (expire)
  );

  iob_pace #(.READ_MIN(READ_MIN), .WRITE_GAP(WRITE_GAP)) u_pace (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .wr_sel_start (wr_sel_start),
    .lat_ok       (lat_ok),
    .gap_free     (gap_free)
  );

  assign bus_addr  = addr_q;
  assign bus_write = wr_q;
  assign bus_wdata = wdata_q;
  assign bus_mask  = mask_q;
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;
endmodule

// File: rtl/iob_master_chk.sv
module iob_master_chk #(
  parameter int DATA_W    = 32,
  parameter int SLOTS     = 8,
  parameter int TIMEOUT   = 255,
  parameter int READ_MIN  = 8,
  parameter int WRITE_GAP = 3,
  localparam int RUN_W = $clog2(TIMEOUT + 2),
  localparam int LAT_W = $clog2(READ_MIN + 1),
  localparam int GAP_W = $clog2(WRITE_GAP + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic [SLOTS-1:0]  bus_sel,
  input logic              bus_write,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_ack,
  input logic              bus_conflict
);
  logic             sel_any, sel_prev, sel_start, last_wr;
  logic [RUN_W-1:0] sel_run;
  logic [LAT_W-1:0] rd_age;
  logic [GAP_W-1:0] wr_since;

  assign sel_any   = |bus_sel;
  assign sel_start = sel_any && !sel_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev <= 1'b0;
      sel_run  <= '0;
      rd_age   <= LAT_W'(READ_MIN);
      wr_since <= GAP_W'(WRITE_GAP);
      last_wr  <= 1'b0;
    end else begin
      sel_prev <= sel_any;
      sel_run  <= sel_any ? sel_run + 1'b1 : '0;
      if (req_valid && req_ready) begin
        rd_age  <= LAT_W'(1);
        last_wr <= req_write;
      end else if (rd_age != LAT_W'(READ_MIN)) begin
        rd_age <= rd_age + 1'b1;
      end
      if (sel_start && bus_write)              wr_since <= GAP_W'(1);
      else if (wr_since != GAP_W'(WRITE_GAP))  wr_since <= wr_since + 1'b1;
    end
  end

  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_sel));

  assert_busy_no_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_any |-> !req_ready);

  assert_rsp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  assert_ack_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_any && bus_ack && !bus_conflict) |=> (bus_sel == '0));

  assert_rd_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_any && bus_ack && !bus_conflict && !bus_write)
      |=> (rsp_rdata == $past(bus_rdata) && !rsp_err));

  assert_conf_backoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_any && bus_conflict) |=> (bus_sel == '0));

  assert_tmo_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_any |-> (sel_run < RUN_W'(TIMEOUT)));

  assert_tmo_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_any && !bus_ack && !bus_conflict && sel_run == RUN_W'(TIMEOUT - 1))
      |=> (bus_sel == '0 && rsp_err));

  assert_rd_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !last_wr) |-> (rd_age >= LAT_W'(READ_MIN)));

  assert_wr_pace_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_start && bus_write) |-> (wr_since >= GAP_W'(WRITE_GAP)));
endmodule

bind iob_master iob_master_chk #(
  .DATA_W(DATA_W), .SLOTS(SLOTS), .TIMEOUT(TIMEOUT),
  .READ_MIN(READ_MIN), .WRITE_GAP(WRITE_GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .bus_sel(bus_sel),
  .bus_write(bus_write), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
  .bus_conflict(bus_conflict)
);

// File: tb/iob_master_tb.sv
`timescale 1ns/1ps
module iob_master_tb;
  localparam int TMO = 255;
  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_mask = '0;
  logic        req_ready, rsp_valid, rsp_err, bus_write;
  logic [31:0] rsp_rdata, bus_addr, bus_wdata;
  logic [3:0]  bus_mask;
  logic [7:0]  bus_sel;
  logic [31:0] bus_rdata = '0;
  logic        bus_ack = 1'b0, bus_conflict = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  iob_master u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .bus_sel(bus_sel),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_mask(bus_mask), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .bus_conflict(bus_conflict)
  );

  int vectors = 0, fails = 0, cyc = 0;

  typedef struct {
    bit wr; int slot; logic [31:0] addr, wdata, rdata; logic [3:0] mask;
    int nconf, cdly, dly; bit noack, both;
  } script_t;
  typedef struct {
    bit wr; logic [31:0] rdata; bit err; int lat; int acc; string tag;
  } exp_t;

  script_t sq[$];
  exp_t    eq[$];
  int      wstarts[$];
  script_t cur;
  bit      active = 0, last_conf = 0;
  int      run = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  // Option-side model: follows the per-transaction script.
  always @(negedge clk) begin
    if (rst_n && |bus_sel) begin
      if (!active) begin
        if (sq.size() == 0) begin
          chk(0, "R1 unexpected select", 32'(bus_sel), 0);
        end else begin
          cur = sq.pop_front();
          active = 1;
        end
      end
      if (run == 0) begin
        chk(bus_sel == 8'(1 << cur.slot), "R1/R4 select slot", 32'(bus_sel), 32'(1 << cur.slot));
        chk(bus_addr == cur.addr, "R1/R4 address", bus_addr, cur.addr);
        chk(bus_write == cur.wr, "R1/R4 direction", 32'(bus_write), 32'(cur.wr));
        if (cur.wr) begin
          chk(bus_wdata == cur.wdata, "R1 write data", bus_wdata, cur.wdata);
          chk(bus_mask == cur.mask, "R1 byte mask", 32'(bus_mask), 32'(cur.mask));
          wstarts.push_back(cyc);
        end
      end
      run++;
      bus_ack = 0; bus_conflict = 0; last_conf = 0;
      bus_rdata = ~32'(cyc);
      if (cur.nconf > 0) begin
        if (run == cur.cdly + 1) begin
          bus_conflict = 1; bus_ack = cur.both; last_conf = 1;
          cur.nconf--;
        end
      end else if (!cur.noack && run == cur.dly + 1) begin
        bus_ack = 1; bus_rdata = cur.rdata; active = 0;
      end
    end else begin
      if (active && run > 0 && !last_conf && cur.noack) begin
        chk(run == TMO, "R5/R6 selected cycles before timeout", 32'(run), 32'(TMO));
        active = 0;
      end
      run = 0; bus_ack = 0; bus_conflict = 0; last_conf = 0;
      bus_rdata = 32'hA5A5_0000 ^ 32'(cyc);
    end
  end

  // Response monitor.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (eq.size() == 0) begin
        chk(0, "R2 unexpected response", rsp_rdata, 0);
      end else begin
        exp_t e;
        int lat;
        e = eq.pop_front();
        lat = cyc - e.acc;
        chk(rsp_rdata == e.rdata, {e.tag, " rdata"}, rsp_rdata, e.rdata);
        chk(rsp_err == e.err, {e.tag, " err"}, 32'(rsp_err), 32'(e.err));
        if (!e.wr) chk(lat >= 8, "R7 read latency minimum", 32'(lat), 8);
        if (e.lat != 0) chk(lat == e.lat, {e.tag, " latency"}, 32'(lat), 32'(e.lat));
      end
    end
  end

  function automatic logic [31:0] mk_addr(input int slot, input logic [21:0] off);
    return (32'(slot) << 22) | 32'(off);
  endfunction

  // Driver: called at a falling edge; returns at the falling edge after acceptance.
  task automatic issue(input bit wr, input int slot, input logic [21:0] off,
                       input logic [31:0] wdata, input logic [3:0] mask,
                       input logic [31:0] rdata, input int nconf, input int cdly,
                       input int dly, input bit noack, input bit both,
                       input bit exp_err, input int exp_lat, input string tag);
    script_t s;
    exp_t e;
    s.wr = wr; s.slot = slot; s.addr = mk_addr(slot, off); s.wdata = wdata;
    s.mask = mask; s.rdata = rdata; s.nconf = nconf; s.cdly = cdly; s.dly = dly;
    s.noack = noack; s.both = both;
    sq.push_back(s);
    req_write = wr; req_addr = s.addr; req_wdata = wdata; req_mask = mask;
    req_valid = 1;
    while (!req_ready) @(negedge clk);
    e.wr = wr; e.err = exp_err; e.lat = exp_lat; e.acc = cyc; e.tag = tag;
    e.rdata = (wr || exp_err) ? 32'h0 : rdata;
    eq.push_back(e);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    while (eq.size() != 0 || active) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1, "R10 ready in reset", 32'(req_ready), 1);
    chk(rsp_valid == 0, "R10 no response in reset", 32'(rsp_valid), 0);
    chk(bus_sel == 0, "R10 no select in reset", 32'(bus_sel), 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && bus_sel == 0, "R10 idle after reset", 32'({req_ready, bus_sel}), 32'h100);

    // R1 R3 R7: read acknowledged in first selected cycle -> exactly 8 cycles.
    issue(0, 2, 22'h00_0040, 0, 0, 32'hCAFE_0001, 0, 0, 0, 0, 0, 0, 8, "R3 R7 fast read");
    drain();

    // R9: write acknowledged at once -> response 2 cycles after acceptance.
    issue(1, 5, 22'h3F_FFFC, 32'h1234_5678, 4'b1010, 0, 0, 0, 0, 0, 0, 0, 2, "R9 fast write");
    drain();

    // R8: back-to-back writes start exactly 3 cycles apart.
    wstarts.delete();
    issue(1, 1, 22'h00_0010, 32'h1111_1111, 4'hF, 0, 0, 0, 0, 0, 0, 0, 0, "R8 write A");
    issue(1, 1, 22'h00_0014, 32'h2222_2222, 4'h3, 0, 0, 0, 0, 0, 0, 0, 0, "R8 write B");
    drain();
    chk(wstarts.size() == 2, "R8 write starts seen", 32'(wstarts.size()), 2);
    if (wstarts.size() == 2)
      chk(wstarts[1] - wstarts[0] == 3, "R8 write spacing", 32'(wstarts[1] - wstarts[0]), 3);

    // R4: read conflicted twice, then acknowledged; answered at the 8-cycle floor.
    issue(0, 6, 22'h00_0100, 0, 0, 32'hBEEF_0002, 2, 0, 0, 0, 0, 0, 8, "R4 retried read");
    drain();

    // R4 R8: write conflicted five times; every reissue paced at 3 cycles.
    wstarts.delete();
    issue(1, 3, 22'h00_0200, 32'h5555_AAAA, 4'h1, 0, 5, 0, 0, 0, 0, 0, 0, "R4 retried write");
    drain();
    chk(wstarts.size() == 6, "R4 write attempts", 32'(wstarts.size()), 6);
    for (int i = 1; i < wstarts.size(); i++)
      chk(wstarts[i] - wstarts[i-1] == 3, "R8 reissue spacing", 32'(wstarts[i] - wstarts[i-1]), 3);

    // R4: conflict together with acknowledge counts as conflict.
    issue(0, 7, 22'h00_0300, 0, 0, 32'h7777_0003, 1, 0, 0, 0, 1, 0, 0, "R4 conflict beats ack");
    drain();

    // R3 R7: slow acknowledge after 12 silent cycles -> response at 14.
    issue(0, 0, 22'h00_0400, 0, 0, 32'h0BAD_F00D, 0, 0, 12, 0, 0, 0, 14, "R3 slow read");
    drain();

    // R5: silent option -> 255 selected cycles then error.
    issue(0, 4, 22'h00_0500, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 1, 0, 1, 0, "R5 timeout read");
    drain();

    // R6: conflict after 200 cycles, then a full fresh window before error.
    issue(1, 2, 22'h00_0600, 32'h6666_6666, 4'hC, 0, 1, 200, 0, 1, 0, 1, 0, "R6 window reload");
    drain();

    // R2: response held while the processor side stalls.
    rsp_ready = 0;
    issue(0, 5, 22'h00_0700, 0, 0, 32'h2468_ACE0, 0, 0, 0, 0, 0, 0, 0, "R2 stalled read");
    while (!rsp_valid) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(rsp_valid == 1, "R2 response held valid", 32'(rsp_valid), 1);
    chk(rsp_rdata == 32'h2468_ACE0, "R2 response data held", rsp_rdata, 32'h2468_ACE0);
    chk(req_ready == 0, "R2 not ready while response waits", 32'(req_ready), 0);
    rsp_ready = 1;
    drain();
    chk(req_ready == 1 && bus_sel == 0, "R2 idle at end", 32'({req_ready, bus_sel}), 32'h100);

    finish_run();
  end
endmodule